// File: doc/BRIEF.md
# Shared Mode-Steered Port FIFO

This block is the one 16-entry byte FIFO behind the FIFO-type register addresses of an extended parallel port. The host side reaches it through four logical FIFO addresses: a compatibility data FIFO, a fast-mode data FIFO, a fast-mode command FIFO and a test FIFO. A three-bit mode field in a small control register decides which of these addresses is live. Each entry also stores a ninth tag bit, so that a later stage can tell command bytes from data bytes.

In the forward direction the host fills the FIFO and the peripheral side drains it. In the reverse direction the peripheral side fills it and the host reads it. The control register holds the mode, a DMA enable, a service-interrupt bit and an error-interrupt enable. It also shows the live full and empty flags. From these bits and the fill level the block raises a DMA request and a one-cycle service-interrupt pulse.

Top module: `shared_port_fifo`

## Requirements
- R1: After reset the FIFO is empty and every control field is 0. `ctl_rdata_o` reads 8'h01, and `dma_req_o` and `svc_irq_o` are both 0.
- R2: The FIFO keeps first-in first-out order over 16 entries. `head_data_o`/`head_tag_o` always show the oldest entry. The full flag (`ctl_rdata_o[1]`) is 1 exactly when 16 entries are held, and the empty flag (`ctl_rdata_o[0]`) is 1 exactly when none are held.
- R3: A push while full, or a pop while empty, leaves the contents, the order and the flags unchanged. When a pop and a push arrive together on a full FIFO, only the pop takes effect.
- R4: The tag bit of an entry is 1 when the host wrote it through the command address (`host_sel_i`=2), and 0 for the host addresses 0, 1 and 3. Entries pushed by the peripheral take their tag from `per_wtag_i`.
- R5: Host address 0 is live only in mode 2 (compatibility FIFO). Addresses 1 and 2 are live only in mode 3 (fast mode). Address 3 is live only in mode 6 (test). Host writes to addresses 0–2 act only when `dir_i`=0, and host reads act only when `dir_i`=1. Address 3 accepts reads and writes in either direction. Any other host access has no effect. A read that coincides with a write is dropped.
- R6: A control write flushes the FIFO when the current mode is 2, 3 or 6 and the written mode differs from it. A control write that leaves the mode unchanged keeps the contents.
- R7: The peripheral pop acts only when `dir_i`=0 and the mode is 2 or 3. The peripheral push acts only when `dir_i`=1 and the mode is 3.
- R8: `dma_req_o` is 1 only when all of the following hold: the DMA enable is 1, the service bit is 0, and the mode is 2 or 3. In that state it follows the FIFO: while `dir_i`=0 it is 1 whenever the FIFO is not full, and while `dir_i`=1 it is 1 whenever the FIFO is not empty.
- R9: When the DMA enable is 0, the service bit is 0 and the mode is 2 or 3, a service condition exists. In the forward direction (`dir_i`=0) the condition is a level of at most DEPTH−THRESH (8). In the reverse direction (`dir_i`=1) it is a level of at least THRESH (8). A service condition in a cycle with no control write sets the service bit at the next edge, and `svc_irq_o` is 1 for that one cycle.
- R10: A control write loads `ctl_wdata_i` = {mode[2:0], err_ien, dma_en, svc}. Reading gives `ctl_rdata_o` = {mode[2:0], err_ien, dma_en, svc, full, empty}. A control write takes priority over a hardware set of the service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dir_i | input | 1 | Transfer direction: 0 forward, 1 reverse |
| host_we_i | input | 1 | Host write strobe to a FIFO address |
| host_re_i | input | 1 | Host read strobe from a FIFO address |
| host_sel_i | input | 2 | FIFO address: 0 compat data, 1 fast data, 2 fast command, 3 test |
| host_wdata_i | input | 8 | Host write byte |
| per_push_i | input | 1 | Peripheral-side push (reverse direction) |
| per_pop_i | input | 1 | Peripheral-side pop (forward direction) |
| per_wdata_i | input | 8 | Peripheral-side byte |
| per_wtag_i | input | 1 | Peripheral-side tag bit |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 6 | Control write value {mode, err_ien, dma_en, svc} |
| head_data_o | output | 8 | Oldest entry byte (first-word fall-through) |
| head_tag_o | output | 1 | Oldest entry tag bit |
| ctl_rdata_o | output | 8 | Control register readback |
| dma_req_o | output | 1 | DMA request |
| svc_irq_o | output | 1 | One-cycle service interrupt pulse |

## Verification
The checker covers several rules on every cycle. The full and empty flags are never both set. A flushing control write always leaves the FIFO empty. A DMA request never appears against a full FIFO in the forward direction or an empty FIFO in the reverse direction. The interrupt pulse lasts one cycle and leaves the service bit set. A host access to a dead address, with no other activity, changes neither the head nor the flags.

The bench scenarios show what a property cannot. These are the true first-in first-out order over a full 16-entry cycle and the tag value of each entry. They also cover the silent drop of pushes on a full FIFO, the choice between flushing and keeping the contents on mode writes, and the exact level at which the service interrupt fires in each direction.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic [2:0] {
    MODE_STD   = 3'd0,
    MODE_BIDIR = 3'd1,
    MODE_CFIFO = 3'd2,
    MODE_FAST  = 3'd3,
    MODE_RSV4  = 3'd4,
    MODE_RSV5  = 3'd5,
    MODE_TEST  = 3'd6,
    MODE_CFG   = 3'd7
  } port_mode_e;

  typedef enum logic [1:0] {
    SEL_CDATA = 2'd0,
    SEL_FDATA = 2'd1,
    SEL_FCMD  = 2'd2,
    SEL_TEST  = 2'd3
  } fifo_sel_e;

  typedef struct packed {
    logic       tag;
    logic [7:0] data;
  } entry_t;

  function automatic logic is_fifo_mode(logic [2:0] m);
    return (m == MODE_CFIFO) || (m == MODE_FAST) || (m == MODE_TEST);
  endfunction

  function automatic logic is_dma_mode(logic [2:0] m);
    return (m == MODE_CFIFO) || (m == MODE_FAST);
  endfunction

  function automatic logic sel_live(logic [1:0] s, logic [2:0] m);
    logic r;
    case (s)
      SEL_CDATA: r = (m == MODE_CFIFO);
      SEL_FDATA: r = (m == MODE_FAST);
      SEL_FCMD:  r = (m == MODE_FAST);
      default:   r = (m == MODE_TEST);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/spf_mem.sv
module spf_mem
  import spf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  entry_t        wentry_i,
  output entry_t        head_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  entry_t        mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (lvl_q == LW'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push_ok) wp_q <= ptr_inc(wp_q);
      if (pop_ok)  rp_q <= ptr_inc(rp_q);
      lvl_q <= lvl_q + LW'(push_ok) - LW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem_q[wp_q] <= wentry_i;
  end

  assign head_o  = mem_q[rp_q];
  assign level_o = lvl_q;
endmodule

// File: rtl/spf_steer.sv
module spf_steer
  import spf_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic       dir_i,
  input  logic       host_we_i,
  input  logic       host_re_i,
  input  logic [1:0] host_sel_i,
  input  logic [7:0] host_wdata_i,
  input  logic       per_push_i,
  input  logic       per_pop_i,
  input  logic [7:0] per_wdata_i,
  input  logic       per_wtag_i,
  output logic       push_o,
  output logic       pop_o,
  output entry_t     wentry_o
);
  logic live, is_test, h_wr, h_rd, p_wr, p_rd;

  assign live    = sel_live(host_sel_i, mode_i);
  assign is_test = (host_sel_i == SEL_TEST);
  // test address works both ways; others follow the direction
  assign h_wr    = host_we_i & live & (~dir_i | is_test);
  assign h_rd    = host_re_i & ~host_we_i & live & (dir_i | is_test);
  assign p_wr    = per_push_i & dir_i & (mode_i == MODE_FAST);
  assign p_rd    = per_pop_i & ~dir_i & is_dma_mode(mode_i);

  assign push_o  = h_wr | p_wr;
  assign pop_o   = h_rd | p_rd;

  always_comb begin
    if (p_wr) begin
      wentry_o.tag  = per_wtag_i;
      wentry_o.data = per_wdata_i;
    end else begin
      wentry_o.tag  = (host_sel_i == SEL_FCMD);
      wentry_o.data = host_wdata_i;
    end
  end
endmodule

// File: rtl/spf_ctl.sv
module spf_ctl
  import spf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int THRESH = 8,
  parameter int LW     = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic [5:0]    ctl_wdata_i,
  input  logic          dir_i,
  input  logic [LW-1:0] level_i,
  input  logic          full_i,
  input  logic          empty_i,
  output logic [2:0]    mode_o,
  output logic          flush_o,
  output logic          dma_req_o,
  output logic          svc_irq_o,
  output logic [7:0]    rdata_o
);
  logic [2:0] mode_q;
  logic       eien_q, dma_q, svc_q, irq_q;
  logic       dma_md, svc_cond;

  assign dma_md   = is_dma_mode(mode_q);
  assign svc_cond = ~dma_q & ~svc_q & dma_md &
                    (dir_i ? (level_i >= LW'(THRESH)) : (level_i <= LW'(DEPTH - THRESH)));
  assign flush_o  = ctl_we_i & is_fifo_mode(mode_q) & (ctl_wdata_i[5:3] != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STD;
      eien_q <= 1'b0;
      dma_q  <= 1'b0;
      svc_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ctl_we_i) {mode_q, eien_q, dma_q, svc_q} <= ctl_wdata_i;
      else if (svc_cond) svc_q <= 1'b1;
      irq_q <= ~ctl_we_i & svc_cond;
    end
  end

  assign dma_req_o = dma_q & ~svc_q & dma_md & (dir_i ? ~empty_i : ~full_i);
  assign svc_irq_o = irq_q;
  assign mode_o    = mode_q;
  assign rdata_o   = {mode_q, eien_q, dma_q, svc_q, full_i, empty_i};
endmodule

// File: rtl/shared_port_fifo.sv
module shared_port_fifo
  import spf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int THRESH = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dir_i,
  input  logic       host_we_i,
  input  logic       host_re_i,
  input  logic [1:0] host_sel_i,
  input  logic [7:0] host_wdata_i,
  input  logic       per_push_i,
  input  logic       per_pop_i,
  input  logic [7:0] per_wdata_i,
  input  logic       per_wtag_i,
  input  logic       ctl_we_i,
  input  logic [5:0] ctl_wdata_i,
  output logic [7:0] head_data_o,
  output logic       head_tag_o,
  output logic [7:0] ctl_rdata_o,
  output logic       dma_req_o,
  output logic       svc_irq_o
);
  localparam int LW = $clog2(DEPTH + 1);

  logic [2:0]    mode;
  logic          push, pop, flush, full, empty;
  logic [LW-1:0] level;
  entry_t        wentry, head;

  spf_steer u_steer (
    .mode_i      (mode),
    .dir_i       (dir_i),
    .host_we_i   (host_we_i),
    .host_re_i   (host_re_i),
    .host_sel_i  (host_sel_i),
    .host_wdata_i(host_wdata_i),
    .per_push_i  (per_push_i),
    .per_pop_i   (per_pop_i),
    .per_wdata_i (per_wdata_i),
    .per_wtag_i  (per_wtag_i),
    .push_o      (push),
    .pop_o       (pop),
    .wentry_o    (wentry)
  );

  spf_mem #(.DEPTH(DEPTH), .LW(LW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (push),
    .pop_i   (pop),
    .wentry_i(wentry),
    .head_o  (head),
    .level_o (level),
    .full_o  (full),
    .empty_o (empty)
  );

  spf_ctl #(.DEPTH(DEPTH), .THRESH(THRESH), .LW(LW)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_we_i   (ctl_we_i),
    .ctl_wdata_i(ctl_wdata_i),
    .dir_i      (dir_i),
    .level_i    (level),
    .full_i     (full),
    .empty_i    (empty),
    .mode_o     (mode),
    .flush_o    (flush),
    .dma_req_o  (dma_req_o),
    .svc_irq_o  (svc_irq_o),
    .rdata_o    (ctl_rdata_o)
  );

  assign head_data_o = head.data;
  assign head_tag_o  = head.tag;
endmodule

// File: rtl/spf_chk.sv
module spf_chk
  import spf_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dir_i,
  input logic       host_we_i,
  input logic       host_re_i,
  input logic [1:0] host_sel_i,
  input logic       per_push_i,
  input logic       per_pop_i,
  input logic       ctl_we_i,
  input logic [5:0] ctl_wdata_i,
  input logic [7:0] head_data_o,
  input logic       head_tag_o,
  input logic [7:0] ctl_rdata_o,
  input logic       dma_req_o,
  input logic       svc_irq_o
);
  logic [2:0] cur_mode;
  logic       dead_wr, dead_rd, quiet_dead;

  assign cur_mode   = ctl_rdata_o[7:5];
  assign dead_wr    = host_we_i &&
                      !(sel_live(host_sel_i, cur_mode) && (!dir_i || host_sel_i == 2'd3));
  assign dead_rd    = !host_we_i && host_re_i &&
                      !(sel_live(host_sel_i, cur_mode) && (dir_i || host_sel_i == 2'd3));
  assign quiet_dead = (dead_wr || dead_rd) && !per_push_i && !per_pop_i && !ctl_we_i;

  p_flags_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_rdata_o[1] && ctl_rdata_o[0]));

  p_dead_access_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet_dead |=> $stable(head_data_o) && $stable(head_tag_o) && $stable(ctl_rdata_o[1:0]));

  p_flush_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && is_fifo_mode(cur_mode) && ctl_wdata_i[5:3] != cur_mode) |=> ctl_rdata_o[0]);

  p_dma_fwd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o && !dir_i) |-> !ctl_rdata_o[1]);

  p_dma_rev_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o && dir_i) |-> !ctl_rdata_o[0]);

  p_irq_bit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_irq_o |-> ctl_rdata_o[2]);

  p_irq_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_irq_o |=> !svc_irq_o);
endmodule

bind shared_port_fifo spf_chk u_chk (.*);

// File: tb/sim_shared_port_fifo.sv
`timescale 1ns/1ps
module sim_shared_port_fifo;
  localparam int D = 16;
  localparam int TH = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic dir_i = 1'b0, host_we_i = 1'b0, host_re_i = 1'b0;
  logic [1:0] host_sel_i = '0;
  logic [7:0] host_wdata_i = '0, per_wdata_i = '0;
  logic per_push_i = 1'b0, per_pop_i = 1'b0, per_wtag_i = 1'b0, ctl_we_i = 1'b0;
  logic [5:0] ctl_wdata_i = '0;
  logic [7:0] head_data_o, ctl_rdata_o;
  logic head_tag_o, dma_req_o, svc_irq_o;

  shared_port_fifo u0 (.*);

  always #4 clk_i = ~clk_i;

  int vectors = 0, fails = 0;
  string cur_req = "R1";

  logic [8:0] mq [D];
  int mcnt = 0;
  logic [2:0] mmode = 3'd0;
  logic meien = 0, mdma = 0, msvc = 0, mirq = 0;

  function automatic logic m_live(logic [1:0] s, logic [2:0] m);
    if (s == 2'd0) return m == 3'd2;
    if (s == 2'd3) return m == 3'd6;
    return m == 3'd3;
  endfunction
  function automatic logic m_dmamode(logic [2:0] m);
    return m == 3'd2 || m == 3'd3;
  endfunction
  function automatic logic m_fifomode(logic [2:0] m);
    return m == 3'd2 || m == 3'd3 || m == 3'd6;
  endfunction
  function automatic logic [7:0] exp_rdata();
    return {mmode, meien, mdma, msvc, mcnt == D, mcnt == 0};
  endfunction
  function automatic logic exp_dma();
    return mdma && !msvc && m_dmamode(mmode) && (dir_i ? mcnt != 0 : mcnt != D);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  task automatic cyc();
    logic wr_ok, rd_ok, pp_ok, po_ok, push, pop, flush, cond;
    logic [8:0] ent;
    int c;
    wr_ok = host_we_i && m_live(host_sel_i, mmode) && (!dir_i || host_sel_i == 2'd3);
    rd_ok = host_re_i && !host_we_i && m_live(host_sel_i, mmode) && (dir_i || host_sel_i == 2'd3);
    pp_ok = per_push_i && dir_i && mmode == 3'd3;
    po_ok = per_pop_i && !dir_i && m_dmamode(mmode);
    push = wr_ok || pp_ok;
    pop = rd_ok || po_ok;
    ent = pp_ok ? {per_wtag_i, per_wdata_i} : {host_sel_i == 2'd2, host_wdata_i};
    flush = ctl_we_i && m_fifomode(mmode) && ctl_wdata_i[5:3] != mmode;
    cond = !mdma && !msvc && m_dmamode(mmode) && (dir_i ? mcnt >= TH : mcnt <= D - TH);
    @(posedge clk_i);
    if (flush) mcnt = 0;
    else begin
      c = mcnt;
      if (pop && c > 0) begin
        for (int i = 0; i < D - 1; i++) mq[i] = mq[i+1];
        mcnt--;
      end
      if (push && c < D) begin
        mq[mcnt] = ent;
        mcnt++;
      end
    end
    if (ctl_we_i) {mmode, meien, mdma, msvc} = ctl_wdata_i;
    else if (cond) msvc = 1'b1;
    mirq = !ctl_we_i && cond;
    @(negedge clk_i);
    chk(cur_req, ctl_rdata_o, exp_rdata());
    chk(cur_req, dma_req_o, exp_dma());
    chk(cur_req, svc_irq_o, mirq);
    if (mcnt > 0) chk(cur_req, {head_tag_o, head_data_o}, mq[0]);
  endtask

  task automatic idle();
    host_we_i = 0; host_re_i = 0; per_push_i = 0; per_pop_i = 0; ctl_we_i = 0;
  endtask
  task automatic ctl(logic [2:0] m, logic e, logic dm, logic sv);
    idle(); ctl_we_i = 1; ctl_wdata_i = {m, e, dm, sv}; cyc(); idle();
  endtask
  task automatic hwr(logic [1:0] s, logic [7:0] d);
    idle(); host_we_i = 1; host_sel_i = s; host_wdata_i = d; cyc(); idle();
  endtask
  task automatic hrd(logic [1:0] s);
    idle(); host_re_i = 1; host_sel_i = s; cyc(); idle();
  endtask
  task automatic ppop();
    idle(); per_pop_i = 1; cyc(); idle();
  endtask
  task automatic ppush(logic [7:0] d, logic t);
    idle(); per_push_i = 1; per_wdata_i = d; per_wtag_i = t; cyc(); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", ctl_rdata_o, 8'h01);
    chk("R1", dma_req_o, 0);
    chk("R1", svc_irq_o, 0);

    // R10 field layout: mode 2, err_ien 1, dma 0, svc 1
    cur_req = "R10";
    ctl(3'd2, 1, 0, 1);
    chk("R10", ctl_rdata_o, 8'h55);

    // R2 fill to 16
    cur_req = "R2";
    for (int i = 0; i < D; i++) begin
      chk("R2", ctl_rdata_o[1], 0);
      hwr(2'd0, 8'(i * 7 + 3));
    end
    chk("R2", ctl_rdata_o[1:0], 2'b10);
    chk("R2", head_data_o, 8'd3);

    // R3 push while full dropped; drain; pop while empty
    cur_req = "R3";
    hwr(2'd0, 8'hAA);
    chk("R3", ctl_rdata_o[1:0], 2'b10);
    chk("R3", head_data_o, 8'd3);
    idle(); per_pop_i = 1; host_we_i = 1; host_sel_i = 2'd0; host_wdata_i = 8'hBB; cyc(); idle();
    chk("R3", head_data_o, 8'd10);
    chk("R3", ctl_rdata_o[1], 0);
    for (int i = 0; i < D - 1; i++) begin
      chk("R3", head_data_o, 8'((i + 1) * 7 + 3));
      ppop();
    end
    chk("R3", ctl_rdata_o[1:0], 2'b01);
    ppop();
    chk("R3", ctl_rdata_o[1:0], 2'b01);

    // R4 tag bits in fast mode
    cur_req = "R4";
    ctl(3'd3, 0, 0, 1);
    hwr(2'd2, 8'h11);
    hwr(2'd1, 8'h22);
    chk("R4", {head_tag_o, head_data_o}, 9'h111);
    ppop();
    chk("R4", {head_tag_o, head_data_o}, 9'h022);
    ppop();

    // R5 dead addresses
    cur_req = "R5";
    hwr(2'd0, 8'h33);
    hwr(2'd3, 8'h44);
    dir_i = 1; hwr(2'd1, 8'h55); dir_i = 0;
    chk("R5", ctl_rdata_o[1:0], 2'b01);
    hwr(2'd1, 8'h66);
    hrd(2'd1);
    chk("R5", head_data_o, 8'h66);
    chk("R5", ctl_rdata_o[0], 0);

    // R7 peripheral pop direction rule
    cur_req = "R7";
    dir_i = 1; ppop(); dir_i = 0;
    chk("R7", ctl_rdata_o[0], 0);
    ppop();
    chk("R7", ctl_rdata_o[0], 1);

    // R6 flush vs keep
    cur_req = "R6";
    hwr(2'd1, 8'h01); hwr(2'd1, 8'h02); hwr(2'd1, 8'h03);
    ctl(3'd3, 1, 0, 1);
    chk("R6", ctl_rdata_o[0], 0);
    chk("R6", head_data_o, 8'h01);
    ctl(3'd0, 0, 0, 1);
    chk("R6", ctl_rdata_o[1:0], 2'b01);

    // R8 DMA request
    cur_req = "R8";
    ctl(3'd3, 0, 1, 0);
    chk("R8", dma_req_o, 1);
    for (int i = 0; i < D; i++) hwr(2'd1, 8'(i));
    chk("R8", dma_req_o, 0);
    dir_i = 1; #1;
    chk("R8", dma_req_o, 1);
    for (int i = 0; i < D; i++) hrd(2'd1);
    chk("R8", dma_req_o, 0);
    dir_i = 0; #1;
    chk("R8", dma_req_o, 1);

    // R9 service interrupt, forward then reverse threshold
    cur_req = "R9";
    ctl(3'd2, 0, 0, 0);
    chk("R9", svc_irq_o, 0);
    idle(); cyc();
    chk("R9", svc_irq_o, 1);
    chk("R9", ctl_rdata_o[2], 1);
    idle(); cyc();
    chk("R9", svc_irq_o, 0);
    ctl(3'd3, 0, 0, 1);
    dir_i = 1;
    for (int i = 0; i < TH - 1; i++) ppush(8'(i), 0);
    ctl(3'd3, 0, 0, 0);
    idle(); cyc();
    chk("R9", svc_irq_o, 0);
    ppush(8'h77, 1);
    chk("R9", svc_irq_o, 0);
    idle(); cyc();
    chk("R9", svc_irq_o, 1);

    // R7 reverse fill with peripheral tags
    cur_req = "R7";
    for (int i = 0; i < TH - 1; i++) hrd(2'd1);
    chk("R7", {head_tag_o, head_data_o}, 9'h177);
    hrd(2'd1);
    chk("R7", ctl_rdata_o[0], 1);
    dir_i = 0; ppush(8'h99, 0);
    chk("R7", ctl_rdata_o[0], 1);

    // mixed random traffic
    cur_req = "R2";
    for (int n = 0; n < 3000; n++) begin
      idle();
      if ($urandom_range(99) < 3) dir_i = ~dir_i;
      if ($urandom_range(99) < 5) begin
        logic [2:0] mv;
        case ($urandom_range(5))
          0: mv = 3'd0; 1: mv = 3'd1; 2: mv = 3'd2;
          3: mv = 3'd3; 4: mv = 3'd6; default: mv = 3'd7;
        endcase
        ctl_we_i = 1;
        ctl_wdata_i = {mv, 3'($urandom_range(7))};
      end
      host_we_i = ($urandom_range(99) < 40);
      host_re_i = ($urandom_range(99) < 35);
      host_sel_i = 2'($urandom_range(3));
      host_wdata_i = 8'($urandom);
      per_push_i = ($urandom_range(99) < 40);
      per_pop_i = ($urandom_range(99) < 35);
      per_wdata_i = 8'($urandom);
      per_wtag_i = 1'($urandom);
      cyc();
    end
    idle();

    summary();
    $finish;
  end
endmodule